// File: doc/BRIEF.md
# Paired Byte-Port GPIO Controller

This block controls sixteen general-purpose pins arranged as two byte-wide ports. Port one occupies bits 7:0 and port two occupies bits 15:8 of one 16-bit register space, so software can reach either port alone with a byte access or both together with a half-word access. Each pin has its own settings for direction, output level, pull resistor enable, pull polarity, interrupt enable and interrupt edge. Input levels are resynchronised through two flops before they are sampled or checked for edges.

Each port keeps its own set of event flags. An edge on a pin of the selected polarity sets that pin's flag, whether or not its interrupt is enabled. Each port also has its own vector register. The vector encodes the lowest-numbered pin that is both flagged and enabled, and reading it acknowledges that pin. Each port drives its own interrupt request line. Port two may implement fewer than eight pins; bits for missing pins hold no state.

Top module: `gpio_pair`

## Requirements
- R1: After synchronous reset, every readable register returns 0, pad_oe, pad_out and pull_en are 0, and both irq lines are 0.
- R2: A write with be=2'b11 updates all 16 bits of a configuration or flag register. be=2'b01 updates only bits 7:0 and be=2'b10 updates only bits 15:8; the other byte keeps its value.
- R3: pad_out always equals the output register (address 1). pad_oe equals the direction register (address 2), where 1 means output.
- R4: pull_en equals the pull-enable register (address 3) with the bits of output pins forced to 0. pull_up equals the pull-select register (address 4), where 1 means pull up.
- R5: The input register (address 0) returns pad_in as seen through a two-flop synchronizer. A pad change shows up in the register after two rising clock edges.
- R6: The edge register (address 6) picks the trigger per pin: 0 means rising, 1 means falling. The selected edge sets the pin's flag (address 7) on the third rising clock edge after the pad changes, even when the pin's interrupt enable (address 5) is 0. The opposite edge leaves the flag unchanged.
- R7: irq[0] is high exactly when some bit in flag[7:0] & enable[7:0] is set. irq[1] does the same for bits 15:8.
- R8: Reading address 8 (port one) or address 9 (port two) returns the vector in rdata[4:0], with rdata[15:5] = 0. The vector is 0 when no flagged pin is enabled. Otherwise it is 2*(i+1), where i is the lowest-numbered pin index within that port whose flag and enable are both set.
- R9: A vector read clears only the flag of the pin it reports. The next-priority pin then comes up, and the other port's flags are untouched.
- R10: Writing the flag register sets and clears flags directly, with byte-lane strobes as in R2, and the irq lines follow.
- R11: With P2_PINS=6, bits 15:14 of every register read as 0 and never drive pad_out, pad_oe or pull_en.
- R12: Writes to address 0 and to addresses 8 and 9 change no state.
- R13: Read data appears on rdata on the clock edge that samples rd_en, and rdata holds that value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| be | input | 2 | Byte-lane enables, bit 0 = port one, bit 1 = port two |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Pin input levels, asynchronous |
| pad_out | output | 16 | Pin output levels |
| pad_oe | output | 16 | Pin output enables |
| pull_en | output | 16 | Pull resistor enables |
| pull_up | output | 16 | Pull polarity, 1 = up |
| irq | output | 2 | Interrupt requests, bit 0 = port one |

## Verification
Register writes take effect on the edge that samples wr_en, so pad_out, pad_oe, pull_en and irq are checked at the following falling edge. A read returns data one edge after rd_en is raised, and the bench samples rdata at the next falling edge. A pad change reaches the input register after two edges and a flag after three. The edge tests sample irq at the falling edges after the second and the third rising edge, to confirm that the flag is absent at the second and present at the third.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

    localparam int PORT_W = 8;
    localparam int NPORT  = 2;
    localparam int DATA_W = PORT_W * NPORT;
    localparam int ADDR_W = 4;
    localparam int VEC_W  = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_IN   = 4'd0,
        RA_OUT  = 4'd1,
        RA_DIR  = 4'd2,
        RA_PEN  = 4'd3,
        RA_PSEL = 4'd4,
        RA_IE   = 4'd5,
        RA_EDGE = 4'd6,
        RA_FLAG = 4'd7,
        RA_VEC1 = 4'd8,
        RA_VEC2 = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic [DATA_W-1:0] out;
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] pen;
        logic [DATA_W-1:0] psel;
        logic [DATA_W-1:0] ie;
        logic [DATA_W-1:0] fall;
    } cfg_t;

    function automatic logic [DATA_W-1:0] pin_mask(input int n1, input int n2);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < PORT_W; i++) begin
            m[i]          = (i < n1);
            m[PORT_W + i] = (i < n2);
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [NPORT-1:0]  lanes,
        input logic [DATA_W-1:0] mask
    );
        logic [DATA_W-1:0] r;
        for (int p = 0; p < NPORT; p++)
            r[p*PORT_W +: PORT_W] = lanes[p] ? new_v[p*PORT_W +: PORT_W]
                                             : old_v[p*PORT_W +: PORT_W];
        return r & mask;
    endfunction

    function automatic logic [VEC_W-1:0] vec_code(input logic [PORT_W-1:0] pend);
        logic [VEC_W-1:0] v;
        v = '0;
        for (int i = PORT_W - 1; i >= 0; i--)
            if (pend[i]) v = VEC_W'(2 * (i + 1));
        return v;
    endfunction

endpackage

// File: rtl/gpio_pair_cfg.sv
module gpio_pair_cfg
    import gpio_pair_pkg::*;
#(
    parameter logic [DATA_W-1:0] MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPORT-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_OUT:  cfg.out  <= lane_merge(cfg.out,  wdata, be, MASK);
                RA_DIR:  cfg.dir  <= lane_merge(cfg.dir,  wdata, be, MASK);
                RA_PEN:  cfg.pen  <= lane_merge(cfg.pen,  wdata, be, MASK);
                RA_PSEL: cfg.psel <= lane_merge(cfg.psel, wdata, be, MASK);
                RA_IE:   cfg.ie   <= lane_merge(cfg.ie,   wdata, be, MASK);
                RA_EDGE: cfg.fall <= lane_merge(cfg.fall, wdata, be, MASK);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pair_sync.sv
module gpio_pair_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] fall_sel,
    output logic [W-1:0] level,
    output logic [W-1:0] evt
);

    logic [W-1:0] meta_q, stab_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= pin_in;
            stab_q <= meta_q;
            last_q <= stab_q;
        end
    end

    assign level = stab_q;

    for (genvar i = 0; i < W; i++) begin : g_det
        assign evt[i] = fall_sel[i] ? (last_q[i] & ~stab_q[i])
                                    : (~last_q[i] & stab_q[i]);
    end

endmodule

// File: rtl/gpio_pair_flags.sv
module gpio_pair_flags
    import gpio_pair_pkg::*;
#(
    parameter logic [PORT_W-1:0] MASK8 = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] evt,
    input  logic [PORT_W-1:0] ie,
    input  logic              fwr,
    input  logic [PORT_W-1:0] fdata,
    input  logic              ack,
    output logic [PORT_W-1:0] flag,
    output logic [VEC_W-1:0]  vec,
    output logic              irq
);

    logic [PORT_W-1:0] pend, lowest, nxt;

    assign pend   = flag & ie;
    assign lowest = pend & (~pend + PORT_W'(1));
    assign vec    = vec_code(pend);
    assign irq    = |pend;

    always_comb begin
        nxt = flag;
        if (ack)
            nxt = nxt & ~lowest;
        if (fwr)
            nxt = fdata;
        nxt = (nxt | evt) & MASK8;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= '0;
        else
            flag <= nxt;
    end

endmodule

// File: rtl/gpio_pair.sv
module gpio_pair
    import gpio_pair_pkg::*;
#(
    parameter int P1_PINS = 8,
    parameter int P2_PINS = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic [15:0] pad_in,
    output logic [15:0] pad_out,
    output logic [15:0] pad_oe,
    output logic [15:0] pull_en,
    output logic [15:0] pull_up,
    output logic [1:0]  irq
);

    localparam logic [DATA_W-1:0] LANE_MASK = pin_mask(P1_PINS, P2_PINS);

    cfg_t              cfg_q;
    logic [DATA_W-1:0] level, evt, flag_all, ie_q;
    logic [VEC_W-1:0]  vec [NPORT];
    logic [DATA_W-1:0] rd_mux;

    gpio_pair_cfg #(.MASK(LANE_MASK)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .be    (be),
        .wdata (wdata),
        .cfg   (cfg_q)
    );

    gpio_pair_sync #(.W(DATA_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pad_in),
        .fall_sel (cfg_q.fall),
        .level    (level),
        .evt      (evt)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic fwr, ack;
        assign fwr = wr_en && (addr == RA_FLAG) && be[p];
        assign ack = rd_en && (addr == ADDR_W'(RA_VEC1 + p));

        gpio_pair_flags #(.MASK8(LANE_MASK[p*PORT_W +: PORT_W])) u_flags (
            .clk   (clk),
            .rst   (rst),
            .evt   (evt[p*PORT_W +: PORT_W]),
            .ie    (cfg_q.ie[p*PORT_W +: PORT_W]),
            .fwr   (fwr),
            .fdata (wdata[p*PORT_W +: PORT_W]),
            .ack   (ack),
            .flag  (flag_all[p*PORT_W +: PORT_W]),
            .vec   (vec[p]),
            .irq   (irq[p])
        );
    end

    assign ie_q = cfg_q.ie;

    always_comb begin
        case (addr)
            RA_IN:   rd_mux = level & LANE_MASK;
            RA_OUT:  rd_mux = cfg_q.out;
            RA_DIR:  rd_mux = cfg_q.dir;
            RA_PEN:  rd_mux = cfg_q.pen;
            RA_PSEL: rd_mux = cfg_q.psel;
            RA_IE:   rd_mux = cfg_q.ie;
            RA_EDGE: rd_mux = cfg_q.fall;
            RA_FLAG: rd_mux = flag_all;
            RA_VEC1: rd_mux = {{(DATA_W-VEC_W){1'b0}}, vec[0]};
            RA_VEC2: rd_mux = {{(DATA_W-VEC_W){1'b0}}, vec[1]};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    assign pad_out = cfg_q.out;
    assign pad_oe  = cfg_q.dir;
    assign pull_en = cfg_q.pen & ~cfg_q.dir;
    assign pull_up = cfg_q.psel;

endmodule

// File: rtl/gpio_pair_chk.sv
module gpio_pair_chk
    import gpio_pair_pkg::*;
#(
    parameter int P1_PINS = 8,
    parameter int P2_PINS = 6
) (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [1:0]  be,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic [15:0] pad_out,
    input logic [15:0] pad_oe,
    input logic [15:0] pull_en,
    input logic [15:0] ie_q,
    input logic [1:0]  irq
);

    localparam logic [15:0] MASK = pin_mask(P1_PINS, P2_PINS);

    AST_PULL_INPUT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (pull_en & pad_oe) == 16'h0);                                            // R4

    AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_OUT && be == 2'b01) |=> pad_out[15:8] == $past(pad_out[15:8])); // R2

    AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_DIR && be == 2'b11) |=> pad_oe == ($past(wdata) & MASK)); // R3

    AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((pad_out | pad_oe | pull_en) & ~MASK) == 16'h0);                        // R11

    AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (ie_q[7:0] == 8'h0) |-> !irq[0]);                                         // R7

    AST_VEC_FORMAT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == RA_VEC1 || addr == RA_VEC2)) |=> (rdata[15:5] == 11'h0 && !rdata[0])); // R8

endmodule

bind gpio_pair gpio_pair_chk #(.P1_PINS(P1_PINS), .P2_PINS(P2_PINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .be      (be),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pull_en (pull_en),
    .ie_q    (ie_q),
    .irq     (irq)
);

// File: tb/gpio_pair_test.sv
`timescale 1ns/1ps
module gpio_pair_test;

    localparam logic [15:0] MSK = 16'h3FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  be = '0;
    logic [15:0] wdata = '0, rdata, pad_in = '0;
    logic [15:0] pad_out, pad_oe, pull_en, pull_up;
    logic [1:0]  irq;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [15:0] mreg [8];
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    gpio_pair uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .be(be), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
        .pull_up(pull_up), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        addr = a; wdata = d; be = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic logic [15:0] merge(logic [15:0] o, logic [15:0] n, logic [1:0] b);
        logic [15:0] r;
        r[7:0]  = b[0] ? n[7:0]  : o[7:0];
        r[15:8] = b[1] ? n[15:8] : o[15:8];
        return r & MSK;
    endfunction

    function automatic logic [4:0] exp_vec(logic [7:0] p);
        for (int i = 0; i < 8; i++)
            if (p[i]) return 5'(2 * i + 2);
        return 5'd0;
    endfunction

    function automatic logic [7:0] low_bit(logic [7:0] p);
        for (int i = 0; i < 8; i++)
            if (p[i]) return 8'(1 << i);
        return 8'h0;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", pad_oe, 16'h0);
        chk("R1 pad_out", pad_out, 16'h0);
        chk("R1 irq", {14'h0, irq}, 16'h0);
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), rv);
            chk("R1 reg", rv, 16'h0);
        end

        // R2 R3 R11 output register lanes
        wr(4'd1, 16'hA5C3, 2'b11);
        chk("R3 pad_out full", pad_out, 16'h25C3);
        rd(4'd1, rv); chk("R11 masked readback", rv, 16'h25C3);
        wr(4'd1, 16'h1234, 2'b01);
        rd(4'd1, rv); chk("R2 low lane", rv, 16'h2534);
        wr(4'd1, 16'hFF00, 2'b10);
        rd(4'd1, rv); chk("R2 high lane", rv, 16'h3F34);
        chk("R11 pad_out top", pad_out & ~MSK, 16'h0);

        // R3 R4 direction and pulls
        wr(4'd2, 16'h00F0, 2'b11);
        wr(4'd3, 16'hFFFF, 2'b11);
        wr(4'd4, 16'h0F0F, 2'b11);
        chk("R3 pad_oe", pad_oe, 16'h00F0);
        chk("R4 pull_en", pull_en, 16'h3F0F);
        chk("R4 pull_up", pull_up, 16'h0F0F);

        // R5 input synchronizer latency and R11 mask
        @(negedge clk); pad_in = 16'hC081;
        @(negedge clk);
        rd(4'd0, rv); chk("R5 input level", rv, 16'h0081);
        @(negedge clk); pad_in = 16'h0000;
        repeat (4) @(negedge clk);
        wr(4'd7, 16'h0000, 2'b11);
        rd(4'd7, rv); chk("R10 flags cleared", rv, 16'h0000);

        // R6 R7 rising edge timing on port one pin 3
        wr(4'd5, 16'h0808, 2'b11);
        @(negedge clk); pad_in = 16'h0008;
        @(negedge clk); @(negedge clk);
        chk("R6 not before third edge", {14'h0, irq}, 16'h0);
        @(negedge clk);
        chk("R6 R7 irq after third edge", {14'h0, irq}, 16'h1);
        rd(4'd8, rv); chk("R8 vec pin3", rv, 16'd8);
        chk("R9 cleared after ack", {14'h0, irq}, 16'h0);
        @(negedge clk); pad_in = 16'h0000;
        repeat (4) @(negedge clk);
        rd(4'd7, rv); chk("R6 falling ignored when rising", rv, 16'h0);

        // R6 falling selection on port two pin 3, flag without enable on pin 0
        wr(4'd6, 16'h0800, 2'b10);
        @(negedge clk); pad_in = 16'h0900;
        repeat (4) @(negedge clk);
        rd(4'd7, rv); chk("R6 rising not selected / rising pin0 flags", rv, 16'h0100);
        chk("R7 no irq without enable", {14'h0, irq}, 16'h0);
        @(negedge clk); pad_in = 16'h0100;
        repeat (4) @(negedge clk);
        chk("R6 R7 falling edge irq", {14'h0, irq}, 16'h2);
        rd(4'd9, rv); chk("R8 vec port2 pin3", rv, 16'd8);
        rd(4'd9, rv); chk("R8 vec skips unenabled", rv, 16'd0);
        rd(4'd7, rv); chk("R9 unenabled flag kept", rv, 16'h0100);

        // R8 R9 priority order
        wr(4'd5, 16'hFFFF, 2'b11);
        wr(4'd7, 16'h11A4, 2'b11);
        rd(4'd8, rv); chk("R8 prio 1", rv, 16'd6);
        rd(4'd8, rv); chk("R8 prio 2", rv, 16'd12);
        rd(4'd7, rv); chk("R9 other port untouched", rv, 16'h1180);
        rd(4'd8, rv); chk("R8 prio 3", rv, 16'd16);
        rd(4'd8, rv); chk("R8 empty", rv, 16'd0);
        rd(4'd9, rv); chk("R8 port2 pin0", rv, 16'd2);

        // R10 flag byte lanes
        wr(4'd7, 16'h0000, 2'b11);
        wr(4'd7, 16'h2040, 2'b10);
        chk("R10 high lane only", {14'h0, irq}, 16'h2);
        wr(4'd7, 16'h0040, 2'b01);
        rd(4'd7, rv); chk("R10 both lanes", rv, 16'h2040);

        // R12 writes to read-only addresses
        wr(4'd0, 16'hFFFF, 2'b11);
        wr(4'd8, 16'h0000, 2'b11);
        wr(4'd9, 16'h0000, 2'b11);
        rd(4'd7, rv); chk("R12 flags unchanged", rv, 16'h2040);
        rd(4'd0, rv); chk("R12 input unchanged", rv, 16'h0100);

        // R13 rdata holds
        repeat (3) @(negedge clk);
        chk("R13 rdata hold", rdata, 16'h0100);

        // random phase, pads static
        for (int a = 1; a < 8; a++) begin
            rd(4'(a), rv); mreg[a] = rv;
        end
        for (int n = 0; n < 400; n++) begin
            logic [3:0]  ra;
            logic [15:0] d;
            logic [1:0]  b;
            logic [7:0]  p;
            ra = 4'($urandom_range(1, 9));
            d  = 16'($urandom);
            b  = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 1) == 0 && ra <= 4'd7) begin
                wr(ra, d, b);
                mreg[ra] = merge(mreg[ra], d, b);
                chk("R3 random pad_out", pad_out, mreg[1]);
                chk("R4 random pull_en", pull_en, mreg[3] & ~mreg[2]);
                chk("R7 random irq", {14'h0, irq},
                    {14'h0, |(mreg[7][15:8] & mreg[5][15:8]), |(mreg[7][7:0] & mreg[5][7:0])});
            end else if (ra >= 4'd8) begin
                rd(ra, rv);
                if (ra == 4'd8) begin
                    p = mreg[7][7:0] & mreg[5][7:0];
                    chk("R8 random vec1", rv, {11'h0, exp_vec(p)});
                    mreg[7][7:0] = mreg[7][7:0] & ~low_bit(p);
                end else begin
                    p = mreg[7][15:8] & mreg[5][15:8];
                    chk("R8 random vec2", rv, {11'h0, exp_vec(p)});
                    mreg[7][15:8] = mreg[7][15:8] & ~low_bit(p);
                end
            end else begin
                rd(ra, rv);
                chk("R2 random readback", rv, mreg[ra]);
            end
        end

        finish_run();
    end

endmodule